// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block orders the movement of data between a volatile SRAM array and the nonvolatile shadow cells that back it. A store copies SRAM into the shadow. It always runs in two timed phases: the old shadow contents are erased first, and then the new contents are programmed. A recall copies the shadow back into SRAM. A recall starts by itself when the block leaves reset, and software can also ask for one with a command.

A store can be started in three ways: a power-fail indication, a hardware store request, or a software store command. The block keeps a flag that records whether any SRAM write has been accepted since the last completed store or recall. Power-fail and hardware stores are skipped while that flag is clear. A software store always runs. Two further commands turn automatic store on power-fail off and on. While a sequence runs, the block drives an active-low busy pin and a ready-status flag for the serial interface. It ignores new requests and SRAM writes during that time. The shadow array is outside the block and is driven through a phase code and two one-cycle strobes.

Top module: `nv_xfer_seq`

## Requirements
- R1: With automatic store enabled and the dirty flag set, a `pwr_fail_i` pulse seen while idle starts a store. Phase code 1 (erase) is shown for ERASE_CYC cycles, then phase code 2 (program) for PROG_CYC cycles, then phase code 0 (idle).
- R2: `nv_prog_stb_o` is high for exactly one cycle, the last cycle of the program phase. The program phase is entered only from the erase phase.
- R3: `busy_n_o` is 0 and `rdy_o` is 1 from the cycle after an accepted trigger until the sequence ends. Both show idle in the cycle after the last phase cycle.
- R4: While the dirty flag is clear, a `pwr_fail_i` or `hw_store_i` pulse seen while idle starts nothing.
- R5: A software store command (`cmd_op_i` = 0 with `cmd_valid_i`) seen while idle starts a store whatever the dirty flag holds.
- R6: `dirty_o` is set by a `sram_wr_i` pulse seen while idle. It is cleared when a store or recall completes. `sram_wr_i` has no effect while busy.
- R7: Command code 2 clears `as_en_o` and command code 3 sets it. While `as_en_o` is 0, `pwr_fail_i` starts nothing.
- R8: A recall (phase code 3) lasts RECALL_CYC cycles. `nv_load_stb_o` is high in its last cycle. It is started by reset or by command code 1 seen while idle.
- R9: Triggers and commands that arrive while busy are ignored. This includes the automatic-store enable commands.
- R10: When triggers coincide, only the highest one is considered: `pwr_fail_i`, then `hw_store_i`, then `cmd_valid_i`. If that trigger is not eligible, the cycle starts nothing.
- R11: After reset the block is busy in phase code 3, with `as_en_o` = 1 and `dirty_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail_i | input | 1 | Power-fail pulse (automatic store request) |
| hw_store_i | input | 1 | Hardware store request pulse |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_op_i | input | 2 | Command: 0 store, 1 recall, 2 autostore off, 3 autostore on |
| sram_wr_i | input | 1 | An SRAM write was performed |
| busy_n_o | output | 1 | Active-low busy; low drives the open-drain pin |
| rdy_o | output | 1 | Busy flag for the status register (1 = busy) |
| as_en_o | output | 1 | Automatic store enabled |
| dirty_o | output | 1 | SRAM written since last store or recall |
| nv_phase_o | output | 2 | 0 idle, 1 erase, 2 program, 3 recall |
| nv_prog_stb_o | output | 1 | Copy SRAM into shadow (last program cycle) |
| nv_load_stb_o | output | 1 | Copy shadow into SRAM (last recall cycle) |

## Verification
Every trigger, command and write is sampled at a rising edge. Its effect on `busy_n_o`, `rdy_o`, `nv_phase_o`, `dirty_o` and `as_en_o` is visible after that same edge, which is one cycle after the stimulus. The strobes depend only on the phase counter. They are therefore due in the final cycle of a phase, which is ERASE_CYC, PROG_CYC or RECALL_CYC cycles after that phase was entered. The bench drives inputs at falling edges. It keeps a behavioural model that advances at every rising edge and compares all outputs at the next falling edge. Directed checks are placed exactly one cycle after the stimulus.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ERASE  = 2'd1,
        PH_PROG   = 2'd2,
        PH_RECALL = 2'd3
    } nv_phase_e;

    typedef enum logic [1:0] {
        OP_STORE  = 2'd0,
        OP_RECALL = 2'd1,
        OP_AS_OFF = 2'd2,
        OP_AS_ON  = 2'd3
    } nv_cmd_e;

    typedef struct packed {
        logic start_store;
        logic start_recall;
        logic as_set;
        logic as_clr;
    } nv_decision_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nv_trig_arb.sv
module nv_trig_arb
    import nv_xfer_pkg::*;
(
    input  logic         idle,
    input  logic         pwr_fail,
    input  logic         hw_store,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic         dirty,
    input  logic         as_en,
    output nv_decision_t dec
);
    always_comb begin
        dec = '0;
        if (idle) begin
            if (pwr_fail) begin
                dec.start_store = as_en && dirty;
            end else if (hw_store) begin
                dec.start_store = dirty;
            end else if (cmd_valid) begin
                unique case (nv_cmd_e'(cmd_op))
                    OP_STORE:  dec.start_store  = 1'b1;
                    OP_RECALL: dec.start_recall = 1'b1;
                    OP_AS_OFF: dec.as_clr       = 1'b1;
                    OP_AS_ON:  dec.as_set       = 1'b1;
                    default:   dec              = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/nv_phase_timer.sv
module nv_phase_timer
    import nv_xfer_pkg::*;
#(
    parameter int unsigned ERASE_CYC  = 6,
    parameter int unsigned PROG_CYC   = 10,
    parameter int unsigned RECALL_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_store,
    input  logic      start_recall,
    output nv_phase_e phase,
    output logic      last,
    output logic      done
);
    localparam int unsigned MAXC  = max3(ERASE_CYC, PROG_CYC, RECALL_CYC);
    localparam int unsigned CNT_W = ($clog2(MAXC) < 1) ? 1 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign last = (phase != PH_IDLE) && (cnt == '0);
    assign done = last && (phase == PH_PROG || phase == PH_RECALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RECALL;
            cnt   <= RECALL_LD;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_store) begin
                        phase <= PH_ERASE;
                        cnt   <= ERASE_LD;
                    end else if (start_recall) begin
                        phase <= PH_RECALL;
                        cnt   <= RECALL_LD;
                    end
                end
                PH_ERASE: begin
                    if (last) begin
                        phase <= PH_PROG;
                        cnt   <= PROG_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nv_flag_regs.sv
module nv_flag_regs
    import nv_xfer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         idle,
    input  logic         sram_wr,
    input  logic         done,
    input  nv_decision_t dec,
    output logic         dirty,
    output logic         as_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
            as_en <= 1'b1;
        end else begin
            if (done) begin
                dirty <= 1'b0;
            end else if (idle && sram_wr) begin
                dirty <= 1'b1;
            end
            if (dec.as_clr) begin
                as_en <= 1'b0;
            end else if (dec.as_set) begin
                as_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
    import nv_xfer_pkg::*;
#(
    parameter int unsigned ERASE_CYC  = 6,
    parameter int unsigned PROG_CYC   = 10,
    parameter int unsigned RECALL_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_fail_i,
    input  logic       hw_store_i,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_op_i,
    input  logic       sram_wr_i,
    output logic       busy_n_o,
    output logic       rdy_o,
    output logic       as_en_o,
    output logic       dirty_o,
    output logic [1:0] nv_phase_o,
    output logic       nv_prog_stb_o,
    output logic       nv_load_stb_o
);
    nv_phase_e    phase;
    logic         last;
    logic         done;
    logic         idle;
    nv_decision_t dec;

    assign idle = (phase == PH_IDLE);

    nv_trig_arb u_arb (
        .idle      (idle),
        .pwr_fail  (pwr_fail_i),
        .hw_store  (hw_store_i),
        .cmd_valid (cmd_valid_i),
        .cmd_op    (cmd_op_i),
        .dirty     (dirty_o),
        .as_en     (as_en_o),
        .dec       (dec)
    );

    nv_phase_timer #(
        .ERASE_CYC  (ERASE_CYC),
        .PROG_CYC   (PROG_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .start_store  (dec.start_store),
        .start_recall (dec.start_recall),
        .phase        (phase),
        .last         (last),
        .done         (done)
    );

    nv_flag_regs u_flags (
        .clk     (clk),
        .rst     (rst),
        .idle    (idle),
        .sram_wr (sram_wr_i),
        .done    (done),
        .dec     (dec),
        .dirty   (dirty_o),
        .as_en   (as_en_o)
    );

    assign busy_n_o      = idle;
    assign rdy_o         = !idle;
    assign nv_phase_o    = phase;
    assign nv_prog_stb_o = last && (phase == PH_PROG);
    assign nv_load_stb_o = last && (phase == PH_RECALL);
endmodule

// File: rtl/nv_xfer_seq_chk.sv
module nv_xfer_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_fail_i,
    input logic       hw_store_i,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_op_i,
    input logic       sram_wr_i,
    input logic       busy_n_o,
    input logic       rdy_o,
    input logic       as_en_o,
    input logic       dirty_o,
    input logic [1:0] nv_phase_o,
    input logic       nv_prog_stb_o,
    input logic       nv_load_stb_o
);
    // R2: erase is followed only by erase or program
    assert_erase_then_prog_R2: assert property (@(posedge clk) disable iff (rst)
        (nv_phase_o == 2'd1) |=> (nv_phase_o == 2'd1 || nv_phase_o == 2'd2));

    // R2: program is entered only from erase
    assert_prog_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (nv_phase_o != 2'd2) |=> (nv_phase_o != 2'd2 || $past(nv_phase_o) == 2'd1));

    // R3: an accepted store makes the busy pin low in the next cycle
    assert_busy_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_n_o && cmd_valid_i && cmd_op_i == 2'd0 && !pwr_fail_i && !hw_store_i)
        |=> (!busy_n_o && rdy_o));

    // R4: a clean array ignores a power-fail pulse
    assert_clean_skip_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_n_o && !dirty_o && pwr_fail_i) |=> busy_n_o);

    // R6: completion of a store clears the dirty flag
    assert_dirty_clear_R6: assert property (@(posedge clk) disable iff (rst)
        nv_prog_stb_o |=> (!dirty_o && busy_n_o));

    // R8: the recall strobe ends the recall
    assert_recall_end_R8: assert property (@(posedge clk) disable iff (rst)
        nv_load_stb_o |=> (nv_phase_o == 2'd0 && !dirty_o));

    // R9: enable commands are ignored while busy
    assert_busy_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_n_o && cmd_valid_i) |=> $stable(as_en_o));

    // R6: writes while busy do not set the flag
    assert_busy_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_n_o && !dirty_o && sram_wr_i) |=> !dirty_o);
endmodule

bind nv_xfer_seq nv_xfer_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pwr_fail_i    (pwr_fail_i),
    .hw_store_i    (hw_store_i),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_op_i      (cmd_op_i),
    .sram_wr_i     (sram_wr_i),
    .busy_n_o      (busy_n_o),
    .rdy_o         (rdy_o),
    .as_en_o       (as_en_o),
    .dirty_o       (dirty_o),
    .nv_phase_o    (nv_phase_o),
    .nv_prog_stb_o (nv_prog_stb_o),
    .nv_load_stb_o (nv_load_stb_o)
);

// File: tb/tb_nv_xfer_seq.sv
`timescale 1ns/1ps
module tb_nv_xfer_seq;
    localparam int ERASE_CYC  = 6;
    localparam int PROG_CYC   = 10;
    localparam int RECALL_CYC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_fail_i = 1'b0, hw_store_i = 1'b0, cmd_valid_i = 1'b0, sram_wr_i = 1'b0;
    logic [1:0] cmd_op_i = 2'd0;
    logic busy_n_o, rdy_o, as_en_o, dirty_o, nv_prog_stb_o, nv_load_stb_o;
    logic [1:0] nv_phase_o;

    always #10 clk = ~clk;

    nv_xfer_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .RECALL_CYC(RECALL_CYC)) dut (
        .clk(clk), .rst(rst), .pwr_fail_i(pwr_fail_i), .hw_store_i(hw_store_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .sram_wr_i(sram_wr_i),
        .busy_n_o(busy_n_o), .rdy_o(rdy_o), .as_en_o(as_en_o), .dirty_o(dirty_o),
        .nv_phase_o(nv_phase_o), .nv_prog_stb_o(nv_prog_stb_o), .nv_load_stb_o(nv_load_stb_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit started  = 1'b0;

    // behavioural reference: phase 0 idle, 1 erase, 2 program, 3 recall
    int m_phase = 3;
    int m_left  = RECALL_CYC;
    bit m_dirty = 1'b0;
    bit m_as    = 1'b1;

    always @(posedge clk) begin
        bit old_dirty;
        if (rst) begin
            m_phase = 3; m_left = RECALL_CYC; m_dirty = 1'b0; m_as = 1'b1;
            started = 1'b1;
        end else if (m_phase != 0) begin
            if (m_left == 1) begin
                if (m_phase == 1) begin
                    m_phase = 2; m_left = PROG_CYC;
                end else begin
                    m_phase = 0; m_dirty = 1'b0;
                end
            end else begin
                m_left = m_left - 1;
            end
        end else begin
            old_dirty = m_dirty;
            if (sram_wr_i) m_dirty = 1'b1;
            if (pwr_fail_i) begin
                if (m_as && old_dirty) begin m_phase = 1; m_left = ERASE_CYC; end
            end else if (hw_store_i) begin
                if (old_dirty) begin m_phase = 1; m_left = ERASE_CYC; end
            end else if (cmd_valid_i) begin
                case (cmd_op_i)
                    2'd0: begin m_phase = 1; m_left = ERASE_CYC; end
                    2'd1: begin m_phase = 3; m_left = RECALL_CYC; end
                    2'd2: m_as = 1'b0;
                    default: m_as = 1'b1;
                endcase
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check("R3 busy_n", busy_n_o, (m_phase == 0) ? 1 : 0);
            check("R3 rdy", rdy_o, (m_phase != 0) ? 1 : 0);
            check("R1 phase", nv_phase_o, m_phase);
            check("R6 dirty", dirty_o, m_dirty);
            check("R7 as_en", as_en_o, m_as);
            check("R2 prog_stb", nv_prog_stb_o, (m_phase == 2 && m_left == 1) ? 1 : 0);
            check("R8 load_stb", nv_load_stb_o, (m_phase == 3 && m_left == 1) ? 1 : 0);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!busy_n_o) @(negedge clk);
    endtask

    task automatic pulse(input bit pf, input bit hw, input bit cv, input logic [1:0] op,
                         input bit wr);
        pwr_fail_i = pf; hw_store_i = hw; cmd_valid_i = cv; cmd_op_i = op; sram_wr_i = wr;
        @(negedge clk);
        pwr_fail_i = 0; hw_store_i = 0; cmd_valid_i = 0; cmd_op_i = 0; sram_wr_i = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                finished = 1'b1;
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R11 reset state (outputs sampled after the last reset edge)
        check("R11 reset busy_n", busy_n_o, 0);
        check("R11 reset phase", nv_phase_o, 3);
        check("R11 reset as_en", as_en_o, 1);
        check("R11 reset dirty", dirty_o, 0);
        wait_idle();
        // R4: clean array ignores power-fail and hardware store
        pulse(1, 0, 0, 2'd0, 0);
        check("R4 pf clean", busy_n_o, 1);
        pulse(0, 1, 0, 2'd0, 0);
        check("R4 hw clean", busy_n_o, 1);
        // R1: write, then power-fail store
        pulse(0, 0, 0, 2'd0, 1);
        check("R6 dirty set", dirty_o, 1);
        pulse(1, 0, 0, 2'd0, 0);
        check("R1 erase start", nv_phase_o, 1);
        wait_idle();
        check("R6 dirty cleared", dirty_o, 0);
        // R5: software store on a clean array
        pulse(0, 0, 1, 2'd0, 0);
        check("R5 sw store", nv_phase_o, 1);
        wait_idle();
        // R7: autostore off blocks power-fail; on again allows it
        pulse(0, 0, 1, 2'd2, 0);
        check("R7 as off", as_en_o, 0);
        pulse(0, 0, 0, 2'd0, 1);
        pulse(1, 0, 0, 2'd0, 0);
        check("R7 pf disabled", busy_n_o, 1);
        pulse(0, 0, 1, 2'd3, 0);
        check("R7 as on", as_en_o, 1);
        // R4 hw store with dirty array
        pulse(0, 1, 0, 2'd0, 0);
        check("R4 hw dirty runs", nv_phase_o, 1);
        // R9: requests while busy are ignored
        pulse(0, 0, 1, 2'd2, 0);
        pulse(0, 0, 0, 2'd0, 1);
        pulse(0, 0, 1, 2'd1, 0);
        check("R9 as kept", as_en_o, 1);
        check("R9 phase kept", nv_phase_o, 1);
        wait_idle();
        check("R9 write ignored", dirty_o, 0);
        // R8: software recall
        pulse(0, 0, 1, 2'd1, 0);
        check("R8 recall start", nv_phase_o, 3);
        wait_idle();
        // R10: power-fail wins over hw and recall command
        pulse(0, 0, 0, 2'd0, 1);
        pulse(1, 1, 1, 2'd1, 0);
        check("R10 pf wins", nv_phase_o, 1);
        wait_idle();
        // R10: ineligible power-fail drops lower triggers
        pulse(0, 0, 1, 2'd2, 0);
        pulse(0, 0, 0, 2'd0, 1);
        pulse(1, 0, 1, 2'd1, 0);
        check("R10 pf blocks cmd", busy_n_o, 1);
        // R10: hardware store beats a command in the same cycle
        pulse(0, 1, 1, 2'd3, 0);
        check("R10 hw wins", nv_phase_o, 1);
        check("R10 cmd dropped", as_en_o, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule